// File: doc/BRIEF.md
# Multidrop Scan Slot Address Matcher

This block gives a scan-test device on a shared multidrop test bus its address decode. A TAP controller elsewhere on the device supplies the current TAP state and the parallel instruction register contents. The instruction register value is compared with the static 8-bit slot identifier strapped on the device. The block classifies the value in one of four ways: a unique slot hit, the broadcast code, the interrogation code, or a multicast group code that matches this device's group register. It then keeps a selection state. That state enables the device's instruction decoding and decides when the device may drive the shared TDO line.

Seven codes are reserved: 0x00, 0x30 to 0x33, 0x38 and 0x3A. The remaining 249 values are usable as unique slot addresses. A device only leaves the unselected state at Update-IR. Once selected, it treats later instruction loads as instructions. It returns to the unselected state on the null code 0x00 or on Test-Logic-Reset. Under interrogation, the device presents its own slot identifier in the next IR scan and then drops out.

Top module: `slotsel`

## Requirements
- R1: While rstN is low, selKind is 0, and selected, instrEn and tdoOe are all 0.
- R2: At a clock edge where tapState is Update-IR (4'hD) and the device is unselected, an irValue equal to slotId selects the device with selKind 1 (unique), provided slotId is not a reserved code.
- R3: A slotId equal to a reserved code (0x00, 0x30-0x33, 0x38, 0x3A) never gives a unique match. An irValue of 0x00 at Update-IR never leaves the device selected.
- R4: At Update-IR while unselected, irValue 0x38 (broadcast) selects every device with selKind 2 (group).
- R5: At Update-IR while unselected, irValue 0x30+g selects with selKind 2 only if the group register is valid and holds g (g in 0..3).
- R6: The 2-bit group register is written from grpIn, and marked valid, on an edge where grpLoad is high and selKind is 1. At any other time grpLoad has no effect. Reset marks the register invalid.
- R7: At Update-IR while unselected, irValue 0x3A (interrogation) gives selKind 3. In this mode, Capture-IR (4'hE) loads slotId, and each Shift-IR (4'hA) edge shifts it toward bit 0. tdo shows the current bit 0, so the identifier leaves LSB first. tdoOe is 1 only in Shift-IR.
- R8: With selKind 3, the next Update-IR returns selKind to 0 whatever irValue holds, even a value matching slotId.
- R9: While selKind is 1 or 2, an Update-IR with any non-zero irValue keeps selKind unchanged. An edge in Test-Logic-Reset (4'hF) returns selKind to 0 from any mode.
- R10: With selKind 1, tdoOe is 1 exactly in Shift-DR (4'h2) and Shift-IR (4'hA). With selKind 0 or 2, tdoOe is always 0.
- R11: selKind changes only at edges in Update-IR or Test-Logic-Reset. While unselected, an Update-IR value that matches nothing leaves selKind at 0.
- R12: selected is 1 whenever selKind is non-zero, and instrEn is 1 exactly when selKind is 1 or 2. With selKind 1, tdo follows chainTdo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tapState | input | 4 | Current TAP controller state code |
| irValue | input | 8 | Parallel instruction register contents |
| slotId | input | 8 | Static slot identifier of this device |
| grpLoad | input | 1 | Request to write the multicast group register |
| grpIn | input | 2 | Group number to write |
| chainTdo | input | 1 | Serial data from the device's own scan path |
| selected | output | 1 | Device is in any selected mode |
| instrEn | output | 1 | Instruction decoding enabled |
| selKind | output | 2 | 0 none, 1 unique, 2 group, 3 interrogation |
| tdoOe | output | 1 | Enable for the shared TDO driver |
| tdo | output | 1 | Serial data toward the shared TDO line |

## Verification
The hardest behaviour to reach from the ports is the interrogation readout. It needs an Update-IR with the interrogation code, then a Capture-IR, then eight Shift-IR edges. The bench samples tdo before each shift edge and compares it with the strapped identifier bit by bit, then checks that a matching address at the closing Update-IR still deselects. The group register is also awkward to reach. A rejected write is only visible through a later multicast probe, so the bench issues a write while group-selected and then shows that the old group still answers and the new one does not.

// File: rtl/slotsel_pkg.sv
package slotsel_pkg;

  // TAP controller state codes as presented on tapState
  localparam logic [3:0] TAP_TLR   = 4'hF;
  localparam logic [3:0] TAP_SHDR  = 4'h2;
  localparam logic [3:0] TAP_CAPIR = 4'hE;
  localparam logic [3:0] TAP_SHIR  = 4'hA;
  localparam logic [3:0] TAP_UPDIR = 4'hD;

  // reserved address codes
  localparam logic [7:0] CODE_NULL  = 8'h00;
  localparam logic [7:0] CODE_BCAST = 8'h38;
  localparam logic [7:0] CODE_QUERY = 8'h3A;
  localparam logic [7:0] CODE_GRP   = 8'h30;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_UNIQUE = 2'd1,
    SEL_GROUP  = 2'd2,
    SEL_QUERY  = 2'd3
  } selKind_t;

  typedef struct packed {
    logic isNull;
    logic hitUnique;
    logic hitBcast;
    logic hitGroup;
    logic hitQuery;
  } addrHits_t;

  typedef struct packed {
    logic loadId;
    logic shiftId;
    logic grpWr;
  } dpStrobes_t;

endpackage

// File: rtl/slotsel_dp.sv
module slotsel_dp
  import slotsel_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int GrpW  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] irValue,
  input  logic [AddrW-1:0] slotId,
  input  logic [GrpW-1:0]  grpIn,
  input  dpStrobes_t       strobes,
  output addrHits_t        hits,
  output logic             idBit
);

  localparam int TagW = AddrW - GrpW;

  localparam logic [AddrW-1:0] NullCode  = AddrW'(CODE_NULL);
  localparam logic [AddrW-1:0] BcastCode = AddrW'(CODE_BCAST);
  localparam logic [AddrW-1:0] QueryCode = AddrW'(CODE_QUERY);
  localparam logic [AddrW-1:0] GrpCode   = AddrW'(CODE_GRP);

  logic [GrpW-1:0]  grpReg;
  logic             grpValid;
  logic [AddrW-1:0] idShift;
  logic             slotReserved;
  logic             irIsGroup;

  // a strapped identifier that collides with a reserved code is unaddressable
  assign slotReserved = (slotId == NullCode) || (slotId == BcastCode) ||
                        (slotId == QueryCode) ||
                        (slotId[AddrW-1:GrpW] == GrpCode[AddrW-1:GrpW]);

  assign irIsGroup = (irValue[AddrW-1:GrpW] == GrpCode[AddrW-1:GrpW]);

  always_comb begin
    hits.isNull    = (irValue == NullCode);
    hits.hitUnique = !slotReserved && (irValue == slotId);
    hits.hitBcast  = (irValue == BcastCode);
    hits.hitQuery  = (irValue == QueryCode);
    hits.hitGroup  = irIsGroup && grpValid && (irValue[GrpW-1:0] == grpReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpReg   <= '0;
      grpValid <= 1'b0;
    end else if (strobes.grpWr) begin
      grpReg   <= grpIn;
      grpValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idShift <= '0;
    end else if (strobes.loadId) begin
      idShift <= slotId;
    end else if (strobes.shiftId) begin
      idShift <= {1'b0, idShift[AddrW-1:1]};
    end
  end

  assign idBit = idShift[0];

endmodule

// File: rtl/slotsel_ctl.sv
module slotsel_ctl
  import slotsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] tapState,
  input  addrHits_t  hits,
  input  logic       grpLoad,
  output selKind_t   kind,
  output dpStrobes_t strobes,
  output logic       tdoOe
);

  selKind_t kindNext;

  always_comb begin
    kindNext = kind;
    if (tapState == TAP_TLR) begin
      kindNext = SEL_NONE;
    end else if (tapState == TAP_UPDIR) begin
      unique case (kind)
        SEL_NONE: begin
          if (hits.hitUnique)                     kindNext = SEL_UNIQUE;
          else if (hits.hitQuery)                 kindNext = SEL_QUERY;
          else if (hits.hitBcast || hits.hitGroup) kindNext = SEL_GROUP;
          else                                    kindNext = SEL_NONE;
        end
        SEL_QUERY: kindNext = SEL_NONE;
        SEL_UNIQUE, SEL_GROUP: begin
          if (hits.isNull) kindNext = SEL_NONE;
        end
        default: kindNext = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kind <= SEL_NONE;
    else       kind <= kindNext;
  end

  always_comb begin
    strobes.loadId  = (kind == SEL_QUERY) && (tapState == TAP_CAPIR);
    strobes.shiftId = (kind == SEL_QUERY) && (tapState == TAP_SHIR);
    strobes.grpWr   = (kind == SEL_UNIQUE) && grpLoad;
  end

  always_comb begin
    unique case (kind)
      SEL_UNIQUE: tdoOe = (tapState == TAP_SHDR) || (tapState == TAP_SHIR);
      SEL_QUERY:  tdoOe = (tapState == TAP_SHIR);
      default:    tdoOe = 1'b0;
    endcase
  end

endmodule

// File: rtl/slotsel.sv
module slotsel
  import slotsel_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int GrpW  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       tapState,
  input  logic [AddrW-1:0] irValue,
  input  logic [AddrW-1:0] slotId,
  input  logic             grpLoad,
  input  logic [GrpW-1:0]  grpIn,
  input  logic             chainTdo,
  output logic             selected,
  output logic             instrEn,
  output logic [1:0]       selKind,
  output logic             tdoOe,
  output logic             tdo
);

  addrHits_t  hits;
  dpStrobes_t strobes;
  selKind_t   kind;
  logic       idBit;

  slotsel_dp #(.AddrW(AddrW), .GrpW(GrpW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irValue (irValue),
    .slotId  (slotId),
    .grpIn   (grpIn),
    .strobes (strobes),
    .hits    (hits),
    .idBit   (idBit)
  );

  slotsel_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .tapState (tapState),
    .hits     (hits),
    .grpLoad  (grpLoad),
    .kind     (kind),
    .strobes  (strobes),
    .tdoOe    (tdoOe)
  );

  assign selKind  = kind;
  assign selected = (kind != SEL_NONE);
  assign instrEn  = (kind == SEL_UNIQUE) || (kind == SEL_GROUP);
  assign tdo      = (kind == SEL_QUERY) ? idBit : chainTdo;

endmodule

// File: rtl/slotsel_chk.sv
module slotsel_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] tapState,
  input logic [7:0] irValue,
  input logic [1:0] selKind,
  input logic       tdoOe
);

  // group and unselected modes never drive the shared line
  assert_group_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (selKind == 2'd0 || selKind == 2'd2) |-> !tdoOe);

  // interrogation drives only during the IR shift
  assert_query_shift_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (selKind == 2'd3 && tdoOe) |-> (tapState == 4'hA));

  assert_tlr_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tapState == 4'hF) |=> (selKind == 2'd0));

  assert_null_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tapState == 4'hD && irValue == 8'h00) |=> (selKind == 2'd0));

  assert_query_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tapState == 4'hD && selKind == 2'd3) |=> (selKind == 2'd0));

  assert_broadcast_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tapState == 4'hD && selKind == 2'd0 && irValue == 8'h38) |=> (selKind == 2'd2));

  assert_hold_outside_update_R11: assert property (@(posedge clk) disable iff (!rstN)
    (tapState != 4'hD && tapState != 4'hF) |=> $stable(selKind));

endmodule

bind slotsel slotsel_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tapState (tapState),
  .irValue  (irValue),
  .selKind  (selKind),
  .tdoOe    (tdoOe)
);

// File: tb/sim_slotsel.sv
`timescale 1ns/1ps
module sim_slotsel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] tapState = 4'hC;
  logic [7:0] irValue = 8'h00;
  logic [7:0] slotId = 8'h5C;
  logic       grpLoad = 1'b0;
  logic [1:0] grpIn = 2'd0;
  logic       chainTdo = 1'b0;
  logic       selected, instrEn, tdoOe, tdo;
  logic [1:0] selKind;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  slotsel u0 (
    .clk(clk), .rstN(rstN), .tapState(tapState), .irValue(irValue),
    .slotId(slotId), .grpLoad(grpLoad), .grpIn(grpIn), .chainTdo(chainTdo),
    .selected(selected), .instrEn(instrEn), .selKind(selKind),
    .tdoOe(tdoOe), .tdo(tdo)
  );

  typedef struct packed {
    logic [3:0] tap;
    logic [7:0] ir;
    logic       gl;
    logic [1:0] gi;
    logic       ct;
    logic [1:0] expKind;
    logic       expOe;
    logic       expTdo;
    logic [7:0] req;
  } vec_t;

  // slotId = 0x5C throughout the table
  localparam vec_t TBL [17] = '{
    '{4'hC, 8'h5C, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd11}, // R11 not in Update-IR
    '{4'hD, 8'h11, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd11}, // R11 no match
    '{4'hD, 8'h5C, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 8'd2},  // R2 unique hit
    '{4'h2, 8'h00, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b1, 8'd10}, // R10 Shift-DR drives
    '{4'hA, 8'h00, 1'b0, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 8'd12}, // R12 tdo follows chain
    '{4'hC, 8'h00, 1'b1, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 8'd6},  // R6 group write
    '{4'hD, 8'h77, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 8'd9},  // R9 instruction keeps
    '{4'hD, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd9},  // R9 null deselects
    '{4'hD, 8'h32, 1'b0, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 8'd5},  // R5 own group
    '{4'h2, 8'h00, 1'b1, 2'd1, 1'b1, 2'd2, 1'b0, 1'b0, 8'd10}, // R10 group quiet, R6 write ignored
    '{4'hD, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd9},
    '{4'hD, 8'h31, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd6},  // R6 group still 2
    '{4'hD, 8'h32, 1'b0, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 8'd5},
    '{4'hA, 8'h00, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 8'd10}, // R10 group quiet in Shift-IR
    '{4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd9},  // R9 TLR
    '{4'hD, 8'h38, 1'b0, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 8'd4},  // R4 broadcast
    '{4'hF, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd9}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] t, input logic [7:0] ir,
                      input logic gl, input logic [1:0] gi, input logic ct);
    @(negedge clk);
    tapState = t; irValue = ir; grpLoad = gl; grpIn = gi; chainTdo = ct;
    @(posedge clk);
    #5;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #5;
    chk("R1 selKind", selKind, 0);
    chk("R1 selected", selected, 0);
    chk("R1 instrEn", instrEn, 0);
    chk("R1 tdoOe", tdoOe, 0);
    @(negedge clk);
    rstN = 1'b1;

    foreach (TBL[i]) begin
      step(TBL[i].tap, TBL[i].ir, TBL[i].gl, TBL[i].gi, TBL[i].ct);
      chk($sformatf("R%0d row%0d selKind", TBL[i].req, i), selKind, TBL[i].expKind);
      chk($sformatf("R%0d row%0d tdoOe", TBL[i].req, i), tdoOe, TBL[i].expOe);
      if (TBL[i].expOe)
        chk($sformatf("R%0d row%0d tdo", TBL[i].req, i), tdo, TBL[i].expTdo);
      // R12 derived flags
      chk($sformatf("R12 row%0d selected", i), selected, TBL[i].expKind != 2'd0);
      chk($sformatf("R12 row%0d instrEn", i), instrEn,
          TBL[i].expKind == 2'd1 || TBL[i].expKind == 2'd2);
    end

    // R7 interrogation readout of 0x5C, LSB first
    step(4'hD, 8'h3A, 1'b0, 2'd0, 1'b0);
    chk("R7 enter", selKind, 3);
    chk("R12 query no instrEn", instrEn, 0);
    step(4'hE, 8'h00, 1'b0, 2'd0, 1'b1);
    chk("R7 capture quiet", tdoOe, 0);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      tapState = 4'hA;
      #1;
      chk($sformatf("R7 oe bit%0d", b), tdoOe, 1);
      chk($sformatf("R7 tdo bit%0d", b), tdo, slotId[b]);
    end
    step(4'h9, 8'h00, 1'b0, 2'd0, 1'b0);
    chk("R7 exit quiet", tdoOe, 0);
    chk("R7 still query", selKind, 3);
    step(4'hD, 8'h5C, 1'b0, 2'd0, 1'b0);
    chk("R8 drop despite match", selKind, 0);
    step(4'hD, 8'h5C, 1'b0, 2'd0, 1'b0);
    chk("R2 reselect", selKind, 1);
    step(4'hF, 8'h00, 1'b0, 2'd0, 1'b0);

    // R3 reserved strap values
    slotId = 8'h38;
    step(4'hD, 8'h38, 1'b0, 2'd0, 1'b0);
    chk("R3 slot 0x38 is broadcast", selKind, 2);
    step(4'hF, 8'h00, 1'b0, 2'd0, 1'b0);
    slotId = 8'h00;
    step(4'hD, 8'h00, 1'b0, 2'd0, 1'b0);
    chk("R3 slot 0x00 unaddressable", selKind, 0);
    slotId = 8'h3A;
    step(4'hD, 8'h3A, 1'b0, 2'd0, 1'b0);
    chk("R3 slot 0x3A is interrogation", selKind, 3);
    step(4'hF, 8'h00, 1'b0, 2'd0, 1'b0);
    slotId = 8'h31;
    step(4'hD, 8'h31, 1'b0, 2'd0, 1'b0);
    chk("R3 slot 0x31 not unique", selKind, 0);

    // R6 reset invalidates group
    slotId = 8'h5C;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1 async reset", selKind, 0);
    @(negedge clk);
    rstN = 1'b1;
    step(4'hD, 8'h32, 1'b0, 2'd0, 1'b0);
    chk("R6 group invalid after reset", selKind, 0);
    step(4'hD, 8'h30, 1'b0, 2'd0, 1'b0);
    chk("R5 group 0 invalid", selKind, 0);

    finishRun();
  end

endmodule